// File: doc/BRIEF.md
# Tiered-Memory Migration Direction Regulator

This block sits beside the access path of a two-tier memory (a small fast tier and a large slow tier) that can move pages between tiers. On every access it looks at a running measure of how many accesses the fast tier has served. It then says whether the page just touched should move up into the fast tier, move down into the slow tier, or stay where it is. The aim is to keep the fast-tier share of traffic close to a programmable target, so that the bandwidth of both tiers is used. The copy engine that moves data and the translation tables are outside the block.

The measurement is kept in two saturating-by-halving counters: one counts fast-tier services, the other counts every access. Together they hold 32 bits of state at the default width. The ratio test has no divider. It compares the fast count times 100 with the thresholds (target minus or plus a guard band, in integer percent) times the total count. Around the target there is a dead band in which no command is issued. A target of 80 suits a fast tier with four times the bandwidth of the slow one. Access strobes are plain control events with no handshake: every strobe is taken in the cycle it appears, and there is no back-pressure. The commands are combinational, one cycle wide, and appear in the same cycle as the strobe.

Top module: `tier_balance_ctrl`

## Requirements
- R1: After reset both counters are zero. Each cycle with `acc_valid` high adds one to the total count, and adds one to the fast count when `acc_fast_hit` is high.
- R2: When an access arrives while the total count holds its maximum value (2^CNT_W-1), the total becomes 2^(CNT_W-1). The fast count becomes (fast + hit) shifted right by one.
- R3: `promote_o` is high when `acc_valid` is high, `acc_fast_hit` is low, the total is nonzero and fast*100 < (target-GUARD_PCT)*total.
- R4: `demote_o` is high when `acc_valid` is high, `acc_fast_hit` is high, the total is nonzero and fast*100 > (target+GUARD_PCT)*total.
- R5: When the measured ratio lies inside the guard band around the target, neither command is issued.
- R6: While the total count is zero, neither command is issued.
- R7: Neither command is asserted in a cycle without `acc_valid`, and the two are never asserted together.
- R8: The decision uses the counter values from before the current access; the current access affects only later decisions.
- R9: For a target below GUARD_PCT the lower threshold is 0, so no promotion is issued. For a target where target+GUARD_PCT is at least 100, no demotion is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | One memory access in this cycle |
| acc_fast_hit | input | 1 | The access was served by the fast tier |
| target_pct | input | PCT_W | Desired fast-tier share in integer percent |
| promote_o | output | 1 | Move the accessed page into the fast tier |
| demote_o | output | 1 | Move the accessed page into the slow tier |

## Verification
The bench builds the block with 6-bit counters, so the halving on overflow happens after 63 accesses and occurs several times in every run. It sweeps every 7-bit target value, including those below the guard band and above 100. Each target gets a fresh reset and a stream with three phases of fast-tier hit density: high, low, then near the target. These phases drive the measured ratio above, below and into the dead band. An arithmetic model of the counters in the bench predicts each command.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  typedef enum logic [1:0] {
    MIG_HOLD    = 2'd0,
    MIG_PROMOTE = 2'd1,
    MIG_DEMOTE  = 2'd2
  } mig_cmd_e;
endpackage

// File: rtl/tbc_counters.sv
module tbc_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_fast_hit,
  output logic [CNT_W-1:0] fast_cnt,
  output logic [CNT_W-1:0] total_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_HALF = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W:0] fast_sum;
  logic           at_max;

  assign fast_sum = {1'b0, fast_cnt} + {{CNT_W{1'b0}}, acc_fast_hit};
  assign at_max   = (total_cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fast_cnt  <= '0;
      total_cnt <= '0;
    end else if (acc_valid) begin
      if (at_max) begin
        total_cnt <= CNT_HALF;
        fast_cnt  <= fast_sum[CNT_W:1];
      end else begin
        total_cnt <= total_cnt + 1'b1;
        fast_cnt  <= fast_sum[CNT_W-1:0];
      end
    end
  end

  AST_FAST_LE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    fast_cnt <= total_cnt); // R1
  AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !at_max) |=> (total_cnt == $past(total_cnt) + 1'b1)); // R1
  AST_TOTAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable(total_cnt)); // R1
  AST_HALVE_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && at_max) |=> (total_cnt == CNT_HALF)); // R2
endmodule

// File: rtl/tbc_ratio_cmp.sv
module tbc_ratio_cmp #(
  parameter int CNT_W     = 16,
  parameter int PCT_W     = 7,
  parameter int GUARD_PCT = 2
) (
  input  logic [CNT_W-1:0] fast_cnt,
  input  logic [CNT_W-1:0] total_cnt,
  input  logic [PCT_W-1:0] target_pct,
  output logic             below_band,
  output logic             above_band,
  output logic             no_history
);
  localparam int PROD_W = CNT_W + PCT_W + 2;
  localparam logic [PCT_W:0] GUARD = (PCT_W+1)'(GUARD_PCT);

  logic [PCT_W:0]  tgt_ext;
  logic [PCT_W:0]  lo_pct;
  logic [PCT_W:0]  hi_pct;
  logic [PROD_W-1:0] fast_scaled;
  logic [PROD_W-1:0] lo_scaled;
  logic [PROD_W-1:0] hi_scaled;

  always_comb begin
    tgt_ext = {1'b0, target_pct};
    lo_pct  = (tgt_ext > GUARD) ? (tgt_ext - GUARD) : '0;
    hi_pct  = tgt_ext + GUARD;
    fast_scaled = PROD_W'(fast_cnt) * PROD_W'(100);
    lo_scaled   = PROD_W'(lo_pct) * PROD_W'(total_cnt);
    hi_scaled   = PROD_W'(hi_pct) * PROD_W'(total_cnt);
    below_band  = fast_scaled < lo_scaled;
    above_band  = fast_scaled > hi_scaled;
    no_history  = (total_cnt == '0);
  end
endmodule

// File: rtl/tier_balance_ctrl.sv
module tier_balance_ctrl #(
  parameter int CNT_W     = 16,
  parameter int PCT_W     = 7,
  parameter int GUARD_PCT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_fast_hit,
  input  logic [PCT_W-1:0] target_pct,
  output logic             promote_o,
  output logic             demote_o
);
  import tbc_pkg::*;

  logic [CNT_W-1:0] fast_cnt;
  logic [CNT_W-1:0] total_cnt;
  logic             below_band;
  logic             above_band;
  logic             no_history;
  mig_cmd_e         cmd;

  tbc_counters #(.CNT_W(CNT_W)) cnt_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_fast_hit (acc_fast_hit),
    .fast_cnt     (fast_cnt),
    .total_cnt    (total_cnt)
  );

  tbc_ratio_cmp #(.CNT_W(CNT_W), .PCT_W(PCT_W), .GUARD_PCT(GUARD_PCT)) cmp_i (
    .fast_cnt   (fast_cnt),
    .total_cnt  (total_cnt),
    .target_pct (target_pct),
    .below_band (below_band),
    .above_band (above_band),
    .no_history (no_history)
  );

  always_comb begin
    cmd = MIG_HOLD;
    if (acc_valid && !no_history) begin
      if (!acc_fast_hit && below_band)     cmd = MIG_PROMOTE;
      else if (acc_fast_hit && above_band) cmd = MIG_DEMOTE;
    end
  end

  assign promote_o = (cmd == MIG_PROMOTE);
  assign demote_o  = (cmd == MIG_DEMOTE);

  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(promote_o && demote_o)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!promote_o && !demote_o)); // R7
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (total_cnt == '0) |-> (!promote_o && !demote_o)); // R6
  AST_PROMOTE_SLOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    promote_o |-> !acc_fast_hit); // R3
  AST_DEMOTE_FAST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    demote_o |-> acc_fast_hit); // R4
  AST_BAND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!below_band && !above_band) |-> (!promote_o && !demote_o)); // R5
endmodule

// File: tb/tier_balance_ctrl_tb_top.sv
module tier_balance_ctrl_tb_top;
  localparam int CNT_W = 6;
  localparam int PCT_W = 7;
  localparam int GUARD = 2;
  localparam int CMAX  = (1 << CNT_W) - 1;
  localparam int RUN_LEN = 150;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             acc_valid = 1'b0;
  logic             acc_fast_hit = 1'b0;
  logic [PCT_W-1:0] target_pct = '0;
  logic             promote_o;
  logic             demote_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int m_fast;
  int m_total;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  tier_balance_ctrl #(.CNT_W(CNT_W), .PCT_W(PCT_W), .GUARD_PCT(GUARD)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_fast_hit (acc_fast_hit),
    .target_pct   (target_pct),
    .promote_o    (promote_o),
    .demote_o     (demote_o)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s tgt=%0d fast=%0d total=%0d {promote,demote} actual=%b expected=%b",
               req, target_pct, m_fast, m_total, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; acc_valid = 1'b0; acc_fast_hit = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_fast = 0; m_total = 0;
    #1;
    check("R1 reset idle", {promote_o, demote_o}, 2'b00);
  endtask

  // One cycle: drive at negedge, compare before the next rising edge (R8: pre-access counts)
  task automatic access(input bit v, input bit hit);
    int lo, hi, tgt;
    bit below, above;
    logic [1:0] exp;
    string req;
    @(negedge clk);
    acc_valid = v; acc_fast_hit = hit;
    #1;
    tgt = int'(target_pct);
    lo = (tgt > GUARD) ? tgt - GUARD : 0;
    hi = tgt + GUARD;
    below = (m_fast * 100) < (lo * m_total);
    above = (m_fast * 100) > (hi * m_total);
    exp = 2'b00;
    if (!v) req = "R7 idle";
    else if (m_total == 0) req = "R6 empty";
    else if (!hit && below) begin exp = 2'b10; req = "R3 promote"; end
    else if (hit && above) begin exp = 2'b01; req = "R4 demote"; end
    else if (!below && !above) req = "R5 band";
    else if (tgt < GUARD || hi >= 100) req = "R9 clamp";
    else req = "R8 other tier";
    if (m_total == CMAX && v) req = {req, " R2 wrap"};
    check(req, {promote_o, demote_o}, exp);
    if (v) begin
      if (m_total == CMAX) begin
        m_total = (m_total + 1) >> 1;
        m_fast  = (m_fast + int'(hit)) >> 1;
      end else begin
        m_total = m_total + 1;
        m_fast  = m_fast + int'(hit);
      end
    end
  endtask

  initial begin
    #(200000 * 10 - 100);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < (1 << PCT_W); t++) begin
      target_pct = PCT_W'(t);
      do_reset();
      // R6: first access after reset sees empty history
      for (int i = 0; i < RUN_LEN; i++) begin
        int bias;
        bit h;
        bias = (i < 50) ? 97 : (i < 100) ? 25 : ((t > 100) ? 100 : t);
        step_lfsr();
        h = (int'(lfsr) % 100) < bias;
        access(1'b1, h);
        if ((i % 17) == 5) access(1'b0, ~h); // R7: idle cycles carry no command
      end
    end
    // R1/R2: long all-fast then all-slow runs across several wraps
    target_pct = 7'd80;
    do_reset();
    for (int i = 0; i < 200; i++) access(1'b1, 1'b1);
    for (int i = 0; i < 200; i++) access(1'b1, 1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule